// File: doc/BRIEF.md
# SENT Fast-Frame Transmitter

This block serialises one fast frame of the single-edge nibble protocol onto one output line. A host presents a status nibble, one to six data nibbles, a nibble count and per-frame settings. It pulses `start` while `ready` is high. The block stores the request and computes the 4-bit checksum in the background. It then drives the line as a run of intervals. Every interval opens with a falling edge, holds the line low for a fixed number of ticks, and then releases it high for the rest of its length.

Time is measured only in `tick_en` strobes. One strobe is one protocol tick, so the tick period is set outside the block. The interval order is sync, status, the data nibbles, the checksum nibble and an optional pause. A nibble with value v lasts v + 12 ticks. The checksum seed and the nibbles it covers are chosen for each frame. `ready` stays low while a frame is in flight, and any request made during that time is dropped.

Top module: `sent_fast_tx`

## Requirements
- R1: After reset and whenever no frame is in flight, `ready` is 1 and `tx_pin` is 1.
- R2: On the clock edge that accepts a request, `tx_pin` falls. The next falling edge follows exactly 56 tick strobes later. That interval is the sync.
- R3: Each nibble interval (status, data, checksum) lasts the nibble value plus 12 ticks, measured between consecutive falling edges.
- R4: In every interval the line stays low for the first 5 ticks after its falling edge and is high for the remaining ticks.
- R5: Interval order is: sync, status, the data nibbles, checksum, pause. Data nibble k is taken from `data_nib[4k+3:4k]` and sent in rising order of k. `nib_count` gives the number of data nibbles: 0 is treated as 1, and values above 6 are treated as 6.
- R6: The checksum uses the generator x^4+x^3+x^2+1 (low bits 0xD). It starts from seed 0x3 when `seed_legacy`=0 and from 0x5 when `seed_legacy`=1. Each covered nibble is folded in one at a time. A final all-zero nibble is then folded in, and the result is sent.
- R7: With `crc_with_status`=1 the checksum covers the status nibble and then the data nibbles. With `crc_with_status`=0 it covers only the data nibbles.
- R8: A `pause_ticks` of 0 sends no pause, and the frame ends at the end of the checksum interval. Values 1 to 11 are raised to 12. Larger values give a pause of exactly that many ticks.
- R9: `ready` drops on the edge that accepts a request. It returns on the tick that ends the last interval. A `start` seen while `ready` is 0 has no effect on the frame being sent or on what follows.
- R10: `tx_pin` changes only on a clock edge where `tick_en` is 1, or on the edge that accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per protocol tick |
| start | input | 1 | Frame request, taken when `ready` is 1 |
| ready | output | 1 | High when a new request can be accepted |
| status_nib | input | 4 | Status nibble |
| data_nib | input | 4*NIB_MAX | Data nibbles, nibble k at bits 4k+3:4k |
| nib_count | input | clog2(NIB_MAX+2) | Number of data nibbles (clamped to 1..NIB_MAX) |
| crc_with_status | input | 1 | 1: checksum covers status and data; 0: data only |
| seed_legacy | input | 1 | 1: seed 0x5; 0: seed 0x3 |
| pause_ticks | input | PAUSE_W | Pause length in ticks; 0 means no pause |
| tx_pin | output | 1 | Serial line, idle high |

## Verification
Two events can land on the same clock edge. One is the tick that closes the last interval of a frame. The other is a held `start` request, which could be taken as a fresh frame on that same edge. The bench provokes this by holding `start` high for the whole frame, with different nibbles and settings, up to and including that closing edge. It passes only if every interval of the frame in flight matches the arithmetic expectation and the line is still idle high one cycle after `ready` returns. A second overlap is between the background checksum fold and the sync interval. The bench runs with a tick on every clock, which gives the fold the least time, and checks the checksum interval length for every seed, coverage mode and nibble count.

// File: rtl/sent_tx_pkg.sv
package sent_tx_pkg;

   localparam logic [3:0] CRC_GEN_LO = 4'hD;
   localparam logic [3:0] SEED_NEW   = 4'h3;
   localparam logic [3:0] SEED_OLD   = 4'h5;

   // Fold one nibble into the running checksum: multiply by x^4 modulo the
   // generator, then add the incoming nibble.
   function automatic logic [3:0] crc4_fold(input logic [3:0] acc, input logic [3:0] nib);
      logic [3:0] r;
      r = acc;
      for (int i = 0; i < 4; i++) begin
         r = r[3] ? ({r[2:0], 1'b0} ^ CRC_GEN_LO) : {r[2:0], 1'b0};
      end
      return r ^ nib;
   endfunction

endpackage

// File: rtl/sent_crc4_serial.sv
module sent_crc4_serial
   import sent_tx_pkg::*;
#(
   parameter int NIB_MAX = 6,
   parameter int NC_W    = $clog2(NIB_MAX + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [3:0]           seed,
   input  logic                 include_status,
   input  logic [3:0]           status_nib,
   input  logic [NIB_MAX*4-1:0] data_nib,
   input  logic [NC_W-1:0]      nib_count,
   output logic [3:0]           crc,
   output logic                 done
);

   localparam int SEQ_N = 2 ** NC_W;

   logic [3:0]      seq [SEQ_N];
   logic [NC_W-1:0] pos;
   logic            running;

   assign seq[0] = status_nib;
   for (genvar k = 0; k < NIB_MAX; k++) begin : g_seq
      assign seq[k+1] = data_nib[4*k +: 4];
   end
   for (genvar k = NIB_MAX + 1; k < SEQ_N; k++) begin : g_pad
      assign seq[k] = 4'h0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc     <= 4'h0;
         pos     <= '0;
         running <= 1'b0;
         done    <= 1'b0;
      end else if (load) begin
         crc     <= seed;
         pos     <= include_status ? NC_W'(0) : NC_W'(1);
         running <= 1'b1;
         done    <= 1'b0;
      end else if (running) begin
         if (pos > nib_count) begin
            crc     <= crc4_fold(crc, 4'h0);
            running <= 1'b0;
            done    <= 1'b1;
         end else begin
            crc <= crc4_fold(crc, seq[pos]);
            pos <= pos + NC_W'(1);
         end
      end
   end

endmodule

// File: rtl/sent_interval_sel.sv
module sent_interval_sel #(
   parameter int NIB_MAX    = 6,
   parameter int NC_W       = $clog2(NIB_MAX + 2),
   parameter int IDX_W      = $clog2(NIB_MAX + 4),
   parameter int LEN_W      = 8,
   parameter int PAUSE_W    = 8,
   parameter int SYNC_TICKS = 56,
   parameter int NIB_OFFSET = 12
) (
   input  logic [IDX_W-1:0]     idx,
   input  logic [3:0]           status_nib,
   input  logic [NIB_MAX*4-1:0] data_nib,
   input  logic [NC_W-1:0]      nib_count,
   input  logic [3:0]           crc,
   input  logic [PAUSE_W-1:0]   pause_len,
   output logic [LEN_W-1:0]     len,
   output logic                 last,
   output logic                 on_crc
);

   localparam int DSEL_N = 2 ** IDX_W;

   logic [3:0]       dsel [DSEL_N];
   logic [IDX_W-1:0] crc_idx;
   logic [IDX_W-1:0] pause_idx;
   logic [IDX_W-1:0] data_off;

   for (genvar k = 0; k < NIB_MAX; k++) begin : g_dsel
      assign dsel[k] = data_nib[4*k +: 4];
   end
   for (genvar k = NIB_MAX; k < DSEL_N; k++) begin : g_dpad
      assign dsel[k] = 4'h0;
   end

   assign crc_idx   = IDX_W'(nib_count) + IDX_W'(2);
   assign pause_idx = IDX_W'(nib_count) + IDX_W'(3);
   assign data_off  = idx - IDX_W'(2);
   assign on_crc    = (idx == crc_idx);
   assign last      = (on_crc && (pause_len == '0)) || (idx == pause_idx);

   always_comb begin
      if (idx == '0) begin
         len = LEN_W'(SYNC_TICKS);
      end else if (idx == IDX_W'(1)) begin
         len = LEN_W'(status_nib) + LEN_W'(NIB_OFFSET);
      end else if (idx < crc_idx) begin
         len = LEN_W'(dsel[data_off]) + LEN_W'(NIB_OFFSET);
      end else if (on_crc) begin
         len = LEN_W'(crc) + LEN_W'(NIB_OFFSET);
      end else begin
         len = LEN_W'(pause_len);
      end
   end

endmodule

// File: rtl/sent_phase_timer.sv
module sent_phase_timer #(
   parameter int LEN_W     = 8,
   parameter int LOW_TICKS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             tick_en,
   input  logic             active,
   input  logic [LEN_W-1:0] len,
   input  logic             more,
   output logic             pin,
   output logic             iv_done
);

   logic [LEN_W-1:0] cnt;
   logic             at_end;

   assign at_end  = (cnt == len - LEN_W'(1));
   assign iv_done = active && tick_en && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin <= 1'b1;
         cnt <= '0;
      end else if (launch) begin
         pin <= 1'b0;
         cnt <= '0;
      end else if (active && tick_en) begin
         if (at_end) begin
            cnt <= '0;
            pin <= !more;
         end else begin
            cnt <= cnt + LEN_W'(1);
            if (cnt == LEN_W'(LOW_TICKS - 1)) begin
               pin <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sent_fast_tx.sv
module sent_fast_tx
   import sent_tx_pkg::*;
#(
   parameter int NIB_MAX    = 6,
   parameter int PAUSE_W    = 8,
   parameter int SYNC_TICKS = 56,
   parameter int LOW_TICKS  = 5,
   parameter int NIB_OFFSET = 12,
   parameter int PAUSE_MIN  = 12,
   localparam int NC_W      = $clog2(NIB_MAX + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 start,
   output logic                 ready,
   input  logic [3:0]           status_nib,
   input  logic [NIB_MAX*4-1:0] data_nib,
   input  logic [NC_W-1:0]      nib_count,
   input  logic                 crc_with_status,
   input  logic                 seed_legacy,
   input  logic [PAUSE_W-1:0]   pause_ticks,
   output logic                 tx_pin
);

   localparam int IDX_W  = $clog2(NIB_MAX + 4);
   localparam int SYNC_W = $clog2(SYNC_TICKS + 1);
   localparam int LEN_W  = (SYNC_W > PAUSE_W) ? SYNC_W : PAUSE_W;

   if (LOW_TICKS < 1 || LOW_TICKS >= NIB_OFFSET) begin : g_bad_low
      $error("LOW_TICKS must be at least 1 and below NIB_OFFSET");
   end
   if (SYNC_TICKS <= NIB_MAX + 2) begin : g_bad_sync
      $error("sync interval too short for the checksum fold");
   end
   if (PAUSE_MIN <= LOW_TICKS || PAUSE_MIN > (2 ** PAUSE_W) - 1) begin : g_bad_pause
      $error("PAUSE_MIN must exceed LOW_TICKS and fit in PAUSE_W");
   end
   if (NIB_MAX < 1) begin : g_bad_nib
      $error("NIB_MAX must be at least 1");
   end

   logic                 busy;
   logic                 accept;
   logic [IDX_W-1:0]     idx;
   logic [3:0]           stat_q;
   logic [NIB_MAX*4-1:0] data_q;
   logic [NC_W-1:0]      cnt_q;
   logic [PAUSE_W-1:0]   pause_q;
   logic [NC_W-1:0]      cnt_eff;
   logic [PAUSE_W-1:0]   pause_eff;
   logic [3:0]           crc_val;
   logic                 crc_done;
   logic [LEN_W-1:0]     iv_len;
   logic                 iv_last;
   logic                 iv_on_crc;
   logic                 iv_done;
   logic                 on_crc_iv;

   assign ready     = !busy;
   assign accept    = start && !busy;
   assign on_crc_iv = busy && iv_on_crc;

   always_comb begin
      if (nib_count == '0) begin
         cnt_eff = NC_W'(1);
      end else if (nib_count > NC_W'(NIB_MAX)) begin
         cnt_eff = NC_W'(NIB_MAX);
      end else begin
         cnt_eff = nib_count;
      end
   end

   always_comb begin
      if (pause_ticks == '0) begin
         pause_eff = '0;
      end else if (pause_ticks < PAUSE_W'(PAUSE_MIN)) begin
         pause_eff = PAUSE_W'(PAUSE_MIN);
      end else begin
         pause_eff = pause_ticks;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         stat_q  <= '0;
         data_q  <= '0;
         cnt_q   <= NC_W'(1);
         pause_q <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         idx     <= '0;
         stat_q  <= status_nib;
         data_q  <= data_nib;
         cnt_q   <= cnt_eff;
         pause_q <= pause_eff;
      end else if (iv_done) begin
         if (iv_last) begin
            busy <= 1'b0;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   sent_crc4_serial #(
      .NIB_MAX (NIB_MAX),
      .NC_W    (NC_W)
   ) u_crc (
      .clk            (clk),
      .rst_n          (rst_n),
      .load           (accept),
      .seed           (seed_legacy ? SEED_OLD : SEED_NEW),
      .include_status (crc_with_status),
      .status_nib     (stat_q),
      .data_nib       (data_q),
      .nib_count      (cnt_q),
      .crc            (crc_val),
      .done           (crc_done)
   );

   sent_interval_sel #(
      .NIB_MAX    (NIB_MAX),
      .NC_W       (NC_W),
      .IDX_W      (IDX_W),
      .LEN_W      (LEN_W),
      .PAUSE_W    (PAUSE_W),
      .SYNC_TICKS (SYNC_TICKS),
      .NIB_OFFSET (NIB_OFFSET)
   ) u_sel (
      .idx        (idx),
      .status_nib (stat_q),
      .data_nib   (data_q),
      .nib_count  (cnt_q),
      .crc        (crc_val),
      .pause_len  (pause_q),
      .len        (iv_len),
      .last       (iv_last),
      .on_crc     (iv_on_crc)
   );

   sent_phase_timer #(
      .LEN_W     (LEN_W),
      .LOW_TICKS (LOW_TICKS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (accept),
      .tick_en (tick_en),
      .active  (busy),
      .len     (iv_len),
      .more    (!iv_last),
      .pin     (tx_pin),
      .iv_done (iv_done)
   );

endmodule

// File: rtl/sent_fast_tx_chk.sv
module sent_fast_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic start,
   input logic ready,
   input logic tx_pin,
   input logic crc_done,
   input logic on_crc_iv
);

   // R1: an idle transmitter holds the line high
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> tx_pin);

   // R9: acceptance drops ready and opens the sync with a falling edge
   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> (!ready && !tx_pin));

   // R9: the frame can only end on a tick
   p_end_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tick_en));

   // R6: checksum fold finished before its interval is sent
   p_crc_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      on_crc_iv |-> crc_done);

   // R10: line moves only on a tick or at acceptance
   p_edge_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_pin) |-> ($past(tick_en) || $past(start && ready)));

endmodule

bind sent_fast_tx sent_fast_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .start     (start),
   .ready     (ready),
   .tx_pin    (tx_pin),
   .crc_done  (crc_done),
   .on_crc_iv (on_crc_iv)
);

// File: tb/sent_fast_tx_tb.sv
module sent_fast_tx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NIB_MAX    = 6;
   localparam int PAUSE_W    = 8;
   localparam int NC_W       = $clog2(NIB_MAX + 2);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 tick_en = 1'b0;
   logic                 start = 1'b0;
   logic                 ready;
   logic [3:0]           status_nib = '0;
   logic [NIB_MAX*4-1:0] data_nib = '0;
   logic [NC_W-1:0]      nib_count = '0;
   logic                 crc_with_status = 1'b0;
   logic                 seed_legacy = 1'b0;
   logic [PAUSE_W-1:0]   pause_ticks = '0;
   logic                 tx_pin;

   int checks = 0;
   int failures = 0;
   int tick_div = 1;
   int tick_total = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sent_fast_tx #(.NIB_MAX(NIB_MAX), .PAUSE_W(PAUSE_W)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick_en         (tick_en),
      .start           (start),
      .ready           (ready),
      .status_nib      (status_nib),
      .data_nib        (data_nib),
      .nib_count       (nib_count),
      .crc_with_status (crc_with_status),
      .seed_legacy     (seed_legacy),
      .pause_ticks     (pause_ticks),
      .tx_pin          (tx_pin)
   );

   always @(posedge clk) begin
      if (tick_en) tick_total <= tick_total + 1;
   end

   initial begin
      int div_ctr;
      div_ctr = 0;
      forever begin
         @(negedge clk);
         if (div_ctr >= tick_div - 1) begin
            tick_en = 1'b1;
            div_ctr = 0;
         end else begin
            tick_en = 1'b0;
            div_ctr++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_feed(input logic [3:0] r, input logic [3:0] nib);
      logic [3:0] q;
      logic       fb;
      q = r;
      for (int b = 3; b >= 0; b--) begin
         fb = q[3];
         q  = {q[2:0], nib[b]};
         if (fb) q = q ^ 4'hD;
      end
      return q;
   endfunction

   function automatic logic [3:0] ref_crc(input bit legacy, input logic [3:0] st,
                                          input logic [23:0] dv, input int ce, input bit withst);
      logic [3:0] r;
      r = legacy ? 4'h5 : 4'h3;
      if (withst) r = ref_feed(r, st);
      for (int k = 0; k < ce; k++) r = ref_feed(r, dv[4*k +: 4]);
      return ref_feed(r, 4'h0);
   endfunction

   task automatic run_frame(input logic [3:0] st, input logic [23:0] dv, input int cnt,
                            input bit legacy, input bit withst, input int pz,
                            input int div, input bit poke);
      int exp_iv[12];
      string tags[12];
      int n_exp, ce, pe, k, last_fall, prev_t, guard;
      logic prev_pin;
      bit done;
      ce = (cnt == 0) ? 1 : ((cnt > NIB_MAX) ? NIB_MAX : cnt);
      pe = (pz == 0) ? 0 : ((pz < 12) ? 12 : pz);
      n_exp = 0;
      exp_iv[n_exp] = 56;      tags[n_exp] = "R2"; n_exp++;
      exp_iv[n_exp] = st + 12; tags[n_exp] = "R3"; n_exp++;
      for (int j = 0; j < ce; j++) begin
         exp_iv[n_exp] = dv[4*j +: 4] + 12; tags[n_exp] = "R5"; n_exp++;
      end
      exp_iv[n_exp] = ref_crc(legacy, st, dv, ce, withst) + 12;
      tags[n_exp] = withst ? "R6" : "R7"; n_exp++;
      if (pe > 0) begin
         exp_iv[n_exp] = pe; tags[n_exp] = "R8"; n_exp++;
      end
      tick_div = div;
      @(negedge clk);
      status_nib = st; data_nib = dv; nib_count = NC_W'(cnt);
      seed_legacy = legacy; crc_with_status = withst; pause_ticks = PAUSE_W'(pz);
      start = 1'b1;
      @(negedge clk);
      if (poke) begin
         status_nib = ~st; data_nib = ~dv; nib_count = NC_W'(NIB_MAX);
         seed_legacy = ~legacy; crc_with_status = ~withst; pause_ticks = '0;
      end else begin
         start = 1'b0;
      end
      check(ready == 1'b0, "R9", "ready after accept", ready, 0);
      check(tx_pin == 1'b0, "R2", "pin falls at accept", tx_pin, 0);
      last_fall = tick_total; prev_t = tick_total; prev_pin = tx_pin;
      k = 0; guard = 0; done = 0;
      while (!done) begin
         @(negedge clk);
         guard++;
         if (tx_pin != prev_pin) begin
            check(tick_total != prev_t, "R10", "pin moved without tick", tick_total - prev_t, 1);
            if (tx_pin) begin
               check(tick_total - last_fall == 5, "R4", "low phase ticks", tick_total - last_fall, 5);
            end else begin
               if (k >= n_exp - 1) begin
                  check(0, "R5", "extra interval", k + 1, n_exp - 1);
                  done = 1;
               end else begin
                  check(tick_total - last_fall == exp_iv[k], tags[k], "interval ticks",
                        tick_total - last_fall, exp_iv[k]);
               end
               k++;
               last_fall = tick_total;
            end
            prev_pin = tx_pin;
         end
         if (ready && !done) begin
            if (k < n_exp)
               check(tick_total - last_fall == exp_iv[k], tags[k], "last interval ticks",
                     tick_total - last_fall, exp_iv[k]);
            check(k == n_exp - 1, "R5", "interval count", k + 1, n_exp);
            check(tx_pin == 1'b1, "R1", "idle level at frame end", tx_pin, 1);
            done = 1;
         end
         prev_t = tick_total;
         if (guard > 2000 * div && !done) begin
            check(0, "R9", "frame did not end", guard, 2000 * div);
            done = 1;
         end
      end
      if (poke) begin
         start = 1'b0;
         @(negedge clk);
         check(ready == 1'b1, "R9", "request during last tick ignored (ready)", ready, 1);
         check(tx_pin == 1'b1, "R9", "request during last tick ignored (pin)", tx_pin, 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL R9: watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pz_set[4];
      logic [23:0] dv;
      pz_set[0] = 0; pz_set[1] = 5; pz_set[2] = 12; pz_set[3] = 40;
      repeat (4) @(negedge clk);
      check(ready == 1'b1, "R1", "ready in reset", ready, 1);
      check(tx_pin == 1'b1, "R1", "pin in reset", tx_pin, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(ready == 1'b1, "R1", "ready idle", ready, 1);
      check(tx_pin == 1'b1, "R1", "pin idle", tx_pin, 1);

      // R3 R6: every status value, mixed seeds, status covered
      for (int s = 0; s < 16; s++) begin
         dv = '0;
         dv[3:0] = 4'(15 - s);
         run_frame(4'(s), dv, 1, s[0], 1'b1, 12, 1, 1'b0);
      end

      // R5 R6 R7 R8 R10: count, seed, coverage, pause and tick rate sweep
      for (int c = 0; c < 8; c++) begin
         for (int m = 0; m < 4; m++) begin
            for (int j = 0; j < NIB_MAX; j++) dv[4*j +: 4] = 4'((j * 7 + c * 5 + m * 3) % 16);
            run_frame(4'((c * 3 + m) % 16), dv, c, m[0], m[1], pz_set[(c + m) % 4],
                      ((c + m) % 2 == 0) ? 1 : 3, 1'b0);
         end
      end

      // R9: request held through the whole frame, including its last tick
      run_frame(4'hA, 24'h5F30C9, 6, 1'b0, 1'b1, 0, 1, 1'b1);
      run_frame(4'h3, 24'h000B07, 3, 1'b1, 1'b0, 20, 2, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule